// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a two-wire bus master that finds out when a serial memory has finished its internal write cycle. Such a memory ignores its bus while it programs, which typically takes a few milliseconds. A single strobe starts the block. It sends a probe transfer: a start condition and then the device address byte with the direction bit cleared. On the ninth clock it samples SDA. If SDA is high, nobody acknowledged, so the device is still busy. The block then sends a stop, which returns the bus to idle, and probes again.

When an acknowledge comes back, the write is complete. The block ends in one of two ways, depending on a flag that names the next operation. If the next operation is a write, the block keeps the transfer open: SCL stays driven low and no stop is sent, so the next write can carry on directly. For any other operation, the block first sends a stop and then reports done. A programmable maximum probe count limits the search. If the count runs out without an acknowledge, the block sends a stop and reports timeout instead.

Both lines are open-drain. Each output means "pull this line low". The SCL timing comes from a clock divider: every bus bit lasts four quarter phases, and each phase lasts CLK_DIV clocks. Because a start condition first releases SDA and then SCL, a new poll can also begin from the held state, where it forms a repeated start.

Top module: `ack_poll_master`

## Requirements
- R1: While reset is high and after it, with no strobe given, `busy_o`, `done_o` and `timeout_o` are low and both `scl_oe_o` and `sda_oe_o` are 0 (both lines released). Reset also releases a line that was being held low.
- R2: Each probe is a start condition (SDA falls while SCL is high), then the byte `{dev_addr_i, 1'b0}` sent MSB first, one bit per SCL high period. The acknowledge is sampled during the ninth SCL high period, and SDA low counts as acknowledge.
- R3: A probe that is not acknowledged is followed by a stop condition (SDA rises while SCL is high) and then by a new probe.
- R4: An acknowledged probe with `next_write_i` latched at 0 is followed by exactly one stop condition. `done_o` then pulses with both lines released.
- R5: An acknowledged probe with `next_write_i` latched at 1 produces no stop. `done_o` pulses while SCL is held low and SDA is released, and the bus stays in that state afterwards.
- R6: Let M be `max_probes_i` latched at the strobe, with 0 treated as 1. If M probes in a row go unacknowledged, the block sends a stop after the last one and pulses `timeout_o` instead of `done_o`, so exactly M probes are made. An acknowledge on probe M still gives done.
- R7: `busy_o` rises in the cycle after the accepted strobe and stays high until the cycle in which `done_o` or `timeout_o` pulses, where it is low. A strobe while busy is ignored, and so is the flag that comes with it.
- R8: During the address and acknowledge bits, the SDA drive changes only while SCL is driven low. SDA changes with SCL high only in start and stop conditions.
- R9: `done_o` and `timeout_o` are never high together, and each is high for a single cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe that begins polling (ignored while busy) |
| next_write_i | input | 1 | Next queued operation is a write; latched at the strobe |
| dev_addr_i | input | 7 | Device address used in the probe byte; latched at the strobe |
| max_probes_i | input | PROBE_W | Maximum number of probes; 0 acts as 1 |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle pulse: the device acknowledged |
| timeout_o | output | 1 | One-cycle pulse: the probe limit was reached without an acknowledge |

## Verification
The bench builds the block with CLK_DIV=2 and PROBE_W=4. The short quarter phase makes one probe take under a hundred clocks, so runs with several unacknowledged probes, timeouts and held-bus repeated starts all fit in a short run. The 4-bit probe limit makes it cheap to reach the timeout boundary exactly, including the case where the acknowledge arrives on the last allowed probe and the case where the limit is zero. A bus model in the bench decodes starts, stops and address bytes from the line levels, and acknowledges only after a chosen number of busy probes.

// File: rtl/ap_pkg.sv
package ap_pkg;

    localparam int BYTE_BITS = 8;

    // Commands accepted by the bit-level engine
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_BYTE  = 2'd1,
        CMD_STOP  = 2'd2
    } bus_cmd_e;

    // Poll sequencer states
    typedef enum logic [2:0] {
        PS_IDLE       = 3'd0,
        PS_START      = 3'd1,
        PS_ADDR       = 3'd2,
        PS_STOP_RETRY = 3'd3,
        PS_STOP_END   = 3'd4,
        PS_STOP_TO    = 3'd5
    } poll_state_e;

    // Probe byte: address with the direction bit cleared (write)
    function automatic logic [7:0] probe_byte(input logic [6:0] addr);
        return {addr, 1'b0};
    endfunction

endpackage

// File: rtl/ap_tick_gen.sv
module ap_tick_gen #(
    parameter int CLK_DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt == LAST);
            cnt    <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ap_bit_engine.sv
module ap_bit_engine
    import ap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     cmd_valid_i,
    input  bus_cmd_e cmd_i,
    input  logic [7:0] tx_byte_i,
    input  logic     sda_i,
    output logic     done_o,
    output logic     ack_o,
    output logic     scl_oe_o,
    output logic     sda_oe_o
);
    localparam logic [3:0] ACK_IDX = 4'(BYTE_BITS);

    logic       active;
    bus_cmd_e   cmd_q;
    logic [1:0] phase;
    logic [3:0] bit_idx;
    logic [7:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cmd_q    <= CMD_START;
            phase    <= 2'd0;
            bit_idx  <= 4'd0;
            shreg    <= 8'd0;
            done_o   <= 1'b0;
            ack_o    <= 1'b0;
            scl_oe_o <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!active) begin
                if (cmd_valid_i) begin
                    active  <= 1'b1;
                    cmd_q   <= cmd_i;
                    phase   <= 2'd0;
                    bit_idx <= 4'd0;
                    shreg   <= tx_byte_i;
                end
            end else if (tick_i) begin
                phase <= phase + 2'd1;
                case (cmd_q)
                    CMD_START: begin
                        // release SDA, release SCL, SDA low (start), SCL low
                        case (phase)
                            2'd0: sda_oe_o <= 1'b0;
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: sda_oe_o <= 1'b1;
                            default: begin
                                scl_oe_o <= 1'b1;
                                active   <= 1'b0;
                                done_o   <= 1'b1;
                            end
                        endcase
                    end
                    CMD_BYTE: begin
                        case (phase)
                            2'd0: begin
                                scl_oe_o <= 1'b1;
                                sda_oe_o <= (bit_idx < ACK_IDX) ? ~shreg[7] : 1'b0;
                            end
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: if (bit_idx == ACK_IDX) ack_o <= ~sda_i;
                            default: begin
                                scl_oe_o <= 1'b1;
                                shreg    <= {shreg[6:0], 1'b0};
                                if (bit_idx == ACK_IDX) begin
                                    active <= 1'b0;
                                    done_o <= 1'b1;
                                end else begin
                                    bit_idx <= bit_idx + 4'd1;
                                end
                            end
                        endcase
                    end
                    default: begin
                        // SCL low with SDA low, release SCL, release SDA (stop)
                        case (phase)
                            2'd0: begin
                                scl_oe_o <= 1'b1;
                                sda_oe_o <= 1'b1;
                            end
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: sda_oe_o <= 1'b0;
                            default: begin
                                active <= 1'b0;
                                done_o <= 1'b1;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    // R8: data bits only move SDA while SCL is driven low
    p_sda_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (active && cmd_q == CMD_BYTE && !scl_oe_o && $past(!scl_oe_o))
        |-> $stable(sda_oe_o));

    // R2: the sequencer only hands over a command when the engine is free
    p_cmd_accept_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_i |-> !active);

endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
    import ap_pkg::*;
#(
    parameter int CLK_DIV = 250,
    parameter int PROBE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               next_write_i,
    input  logic [6:0]         dev_addr_i,
    input  logic [PROBE_W-1:0] max_probes_i,
    input  logic               sda_i,
    output logic               scl_oe_o,
    output logic               sda_oe_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               timeout_o
);
    localparam logic [PROBE_W-1:0] ONE = PROBE_W'(1);

    poll_state_e        state;
    logic               issued;
    logic               wr_q;
    logic [6:0]         addr_q;
    logic [PROBE_W-1:0] max_q;
    logic [PROBE_W-1:0] cnt;
    logic [PROBE_W-1:0] cnt_inc;

    logic     tick;
    logic     cmd_valid;
    bus_cmd_e cmd;
    logic     eng_done;
    logic     eng_ack;

    assign cnt_inc   = cnt + ONE;
    assign cmd_valid = (state != PS_IDLE) && !issued;

    always_comb begin
        case (state)
            PS_START: cmd = CMD_START;
            PS_ADDR:  cmd = CMD_BYTE;
            default:  cmd = CMD_STOP;
        endcase
    end

    ap_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    ap_bit_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .tx_byte_i   (probe_byte(addr_q)),
        .sda_i       (sda_i),
        .done_o      (eng_done),
        .ack_o       (eng_ack),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_IDLE;
            issued    <= 1'b0;
            wr_q      <= 1'b0;
            addr_q    <= 7'd0;
            max_q     <= ONE;
            cnt       <= '0;
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
            if (state == PS_IDLE) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    wr_q   <= next_write_i;
                    addr_q <= dev_addr_i;
                    max_q  <= (max_probes_i == '0) ? ONE : max_probes_i;
                    cnt    <= '0;
                    issued <= 1'b0;
                    state  <= PS_START;
                end
            end else begin
                if (cmd_valid) issued <= 1'b1;
                if (eng_done) begin
                    issued <= 1'b0;
                    case (state)
                        PS_START: state <= PS_ADDR;
                        PS_ADDR: begin
                            if (eng_ack) begin
                                if (wr_q) begin
                                    done_o <= 1'b1;
                                    busy_o <= 1'b0;
                                    state  <= PS_IDLE;
                                end else begin
                                    state <= PS_STOP_END;
                                end
                            end else begin
                                cnt   <= cnt_inc;
                                state <= (cnt_inc >= max_q) ? PS_STOP_TO : PS_STOP_RETRY;
                            end
                        end
                        PS_STOP_RETRY: state <= PS_START;
                        PS_STOP_END: begin
                            done_o <= 1'b1;
                            busy_o <= 1'b0;
                            state  <= PS_IDLE;
                        end
                        default: begin
                            timeout_o <= 1'b1;
                            busy_o    <= 1'b0;
                            state     <= PS_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    // R9: completion flags are exclusive single-cycle pulses
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_tmo_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    // R7: busy only drops together with a completion flag
    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o || timeout_o));

    // R6: never more unanswered probes than the latched limit
    p_probe_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt <= max_q));

    // R5: write-continue ending keeps SCL held low with SDA released
    p_hold_bus_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && wr_q) |-> (scl_oe_o && !sda_oe_o));

    // R4: other endings leave both lines released
    p_release_bus_r4: assert property (@(posedge clk) disable iff (rst)
        ((done_o && !wr_q) || timeout_o) |-> (!scl_oe_o && !sda_oe_o));

endmodule

// File: tb/test_ack_poll_master.sv
module test_ack_poll_master;
    localparam int DIV = 2;
    localparam int PW  = 4;
    localparam logic [6:0] ADDR = 7'h53;

    // Vector fields: [8:5] busy probes before ack, [4] next is write, [3:0] probe limit
    localparam int NV = 7;
    localparam logic [8:0] VECS [NV] = '{
        {4'd0, 1'b0, 4'd4},
        {4'd3, 1'b0, 4'd8},
        {4'd2, 1'b1, 4'd8},
        {4'd0, 1'b1, 4'd2},
        {4'd5, 1'b0, 4'd3},
        {4'd2, 1'b0, 4'd3},
        {4'd1, 1'b1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic nwr = 1'b0;
    logic [PW-1:0] maxp = '0;
    logic scl_oe, sda_oe, busy, done, tmo;
    logic pull = 1'b0;
    wire  scl_l = ~scl_oe;
    wire  sda_l = ~(sda_oe | pull);

    always #5 clk = ~clk;

    ack_poll_master #(.CLK_DIV(DIV), .PROBE_W(PW)) i_ack_poll_master (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .next_write_i (nwr),
        .dev_addr_i   (ADDR),
        .max_probes_i (maxp),
        .sda_i        (sda_l),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .busy_o       (busy),
        .done_o       (done),
        .timeout_o    (tmo)
    );

    // Bus target model: decodes the lines, acknowledges after nacks busy probes
    int nacks = 0, probes = 0, stops = 0, addr_err = 0, bc = 0;
    logic scl_p = 1'b1, sda_p = 1'b1, in_x = 1'b0;
    logic [7:0] sh = 8'd0;

    always @(negedge clk) begin
        if (scl_l && scl_p && sda_p && !sda_l) begin
            in_x = 1'b1; bc = 0; sh = 8'd0;
        end else if (scl_l && scl_p && !sda_p && sda_l) begin
            stops++; in_x = 1'b0;
        end else if (in_x) begin
            if (scl_l && !scl_p) begin
                if (bc < 8) sh = {sh[6:0], sda_l};
                bc++;
            end else if (!scl_l && scl_p) begin
                if (bc == 8) begin
                    probes++;
                    if (sh != {ADDR, 1'b0}) addr_err++;
                    if (probes > nacks) pull = 1'b1;
                end else if (bc == 9) begin
                    pull = 1'b0; in_x = 1'b0;
                end
            end
        end
        scl_p = scl_l;
        sda_p = sda_l;
    end

    int checks = 0, fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int nk, input bit wr, input int mx, input bit poke);
        int eff, e_tmo, e_probes, e_stops, e_held;
        int busy_bad, got_done, got_tmo, busy_end, seen;
        eff      = (mx == 0) ? 1 : mx;
        e_tmo    = (nk >= eff) ? 1 : 0;
        e_probes = e_tmo ? eff : nk + 1;
        e_held   = (!e_tmo && wr) ? 1 : 0;
        e_stops  = e_held ? e_probes - 1 : e_probes;
        @(negedge clk);
        nacks = nk; probes = 0; stops = 0; addr_err = 0;
        nwr = wr; maxp = PW'(mx); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_bad = 0; got_done = 0; got_tmo = 0; busy_end = 1; seen = 0;
        for (int i = 0; i < 20000; i++) begin
            if (done || tmo) begin
                got_done = done; got_tmo = tmo; busy_end = busy; seen = 1;
                break;
            end
            if (!busy) busy_bad++;
            if (poke && i == 30) begin
                start = 1'b1; nwr = ~wr; maxp = PW'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R7 watchdog terminal flag seen", seen, 1);
        chk("R7 busy high throughout run", busy_bad, 0);
        chk("R7 busy low at completion", busy_end, 0);
        chk("R6 timeout flag", got_tmo, e_tmo);
        chk("R4 done flag", got_done, 1 - e_tmo);
        chk("R3 probe count", probes, e_probes);
        chk("R2 probe address byte errors", addr_err, 0);
        chk(e_held ? "R5 stop count" : "R4 stop count", stops, e_stops);
        repeat (6) @(negedge clk);
        chk("R9 flags cleared after pulse", int'(done) + int'(tmo), 0);
        chk(e_held ? "R5 SCL held low" : "R4 SCL released", int'(scl_l), 1 - e_held);
        chk("R5 SDA released", int'(sda_l), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 lines in reset", int'(scl_l) + int'(sda_l), 2);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 idle after reset", int'(busy) + int'(done) + int'(tmo), 0);
        chk("R1 lines idle after reset", int'(scl_l) + int'(sda_l), 2);

        for (int v = 0; v < NV; v++) begin
            run(int'(VECS[v][8:5]), VECS[v][4], int'(VECS[v][3:0]), 1'b0);
        end

        // R7: strobe while busy is ignored, including its flag and limit
        run(2, 1'b0, 4, 1'b1);

        // R1: reset releases a held SCL
        run(0, 1'b1, 3, 1'b0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 reset releases held bus", int'(scl_l) + int'(sda_l), 2);
        chk("R1 busy low after reset", int'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end
endmodule